// File: doc/BRIEF.md
# Three-Wire Serial Nonvolatile Memory Device Controller

This block is the device end of a three-wire serial memory link. The host raises chip select and clocks bits in on the data-in line. Each instruction is a start bit, a 2-bit opcode, an address and, for writes, a data word. The block decodes word read, word write, word erase, whole-array clear, whole-array fill, program enable and program disable. It drives the data-out line with read data or with a ready/busy flag. The storage is an on-chip register array of 1024 bits. A configuration input presents it as 64 words of 16 bits or as 128 bytes.

The serial clock and chip select are sampled with the system clock, so their edges are found inside the block. Program operations do not complete at once. The falling edge of chip select after a complete program instruction starts a timed cycle of `PROG_CYCLES` system clocks. During that cycle the block shows busy and ignores every new instruction. A program-enable latch, cleared by reset, blocks all program operations until the host enables them.

Top module: `mw_eeprom`

## Requirements
- R1: An instruction begins at the first 1 sampled on di at a rising sck edge while cs is high; zeros before it are skipped. The next two bits are the opcode: 10 read, 01 write, 11 erase, 00 extended group.
- R2: When org_x16 is 1, the address field is 6 bits and data is 16 bits. When org_x16 is 0, the address field is 7 bits and data is 8 bits. Byte address 2k is the high byte and byte address 2k+1 is the low byte of word k.
- R3: After reset the program-enable latch is clear. Write, erase, clear and fill are then ignored: the array is unchanged and dout never shows busy.
- R4: In the extended group the two most significant address bits select the command: 11 enable, 00 disable, 10 clear array, 01 fill array. After an enable, program operations take effect until a disable or a reset.
- R5: Erase sets every bit of the addressed word (or byte) to 1.
- R6: Write stores the shifted data at the address. The cycle starts when cs falls after the last data bit (after the last address bit for erase and clear). If another rising sck edge comes before cs falls, the instruction is dropped.
- R7: dout is low (busy) while a program cycle runs. The cycle lasts PROG_CYCLES clocks and starts within 3 clocks of the cs fall. After it, dout is high.
- R8: Clear sets the whole array to all ones. Fill writes the shifted pattern into every word (or byte), whatever it held before.
- R9: Read drives a 0 on dout after the last address bit. It then drives the data MSB first, one bit per rising sck. While cs stays high the address advances and the next word follows. The address wraps from the top address to 0.
- R10: Any instruction whose start bit arrives while a program cycle runs is ignored.
- R11: cs low abandons a partly received instruction with no effect, and the next frame decodes from its own start bit.
- R12: During and after reset, dout is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial lines are sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| org_x16 | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial read data or ready (1) / busy (0) status |

## Verification
The bench checks several corner cases:
- Sequential reads that cross the top address in both organizations. A wrong wrap would return a word from beyond the array or a stale word.
- A byte write followed by a word read. A wrong lane choice would show up as a swapped half.
- An extra clock between the last data bit and the cs fall. A design that kept the instruction armed would program it.
- A cs drop in mid-address, followed by a clean frame. A design that kept shift state across frames would misdecode that frame.
- A second program instruction sent while busy, and program operations sent before enable or after disable. A design that accepted either would change a word the model keeps fixed, or would show busy where ready is expected.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_ARMED, ST_READ, ST_DROP
  } mw_state_t;

  typedef enum logic [1:0] {
    PK_WORD, PK_ERASE, PK_FILL, PK_CLEAR
  } prog_kind_t;

  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] EXT_DIS   = 2'b00;
  localparam logic [1:0] EXT_FILL  = 2'b01;
  localparam logic [1:0] EXT_CLEAR = 2'b10;
  localparam logic [1:0] EXT_EN    = 2'b11;

endpackage

// File: rtl/mw_mem.sv
module mw_mem #(
  parameter int WA = 6
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [WA-1:0] rd_word,
  output logic [15:0]   rd_q,
  input  logic          we,
  input  logic [WA-1:0] we_word,
  input  logic [1:0]    we_be,
  input  logic [15:0]   we_data
);
  localparam int NW = 1 << WA;

  // one byte-wide lane per half word, so byte writes need no read-modify-write
  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [7:0] lane [NW];
    always_ff @(posedge clk) begin
      if (we && we_be[l]) lane[we_word] <= we_data[8*l +: 8];
      if (rd_en) rd_q[8*l +: 8] <= lane[rd_word];
    end
  end

endmodule

// File: rtl/mw_prog.sv
module mw_prog
  import mw_pkg::*;
#(
  parameter int WA          = 6,
  parameter int PROG_CYCLES = 400
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  prog_kind_t    kind,
  input  logic          org_x16,
  input  logic [WA:0]   addr,
  input  logic [15:0]   data,
  output logic          busy,
  output logic          we,
  output logic [WA-1:0] we_word,
  output logic [1:0]    we_be,
  output logic [15:0]   we_data
);
  localparam int NW = 1 << WA;
  localparam int TW = $clog2(PROG_CYCLES + 1);

  logic [TW-1:0] timer;
  logic          bulk;
  logic          is_bulk, is_ones;

  assign is_bulk = (kind == PK_FILL) || (kind == PK_CLEAR);
  assign is_ones = (kind == PK_ERASE) || (kind == PK_CLEAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      timer   <= '0;
      we      <= 1'b0;
      bulk    <= 1'b0;
      we_word <= '0;
      we_be   <= 2'b00;
      we_data <= '0;
    end else if (go && !busy) begin
      busy    <= 1'b1;
      timer   <= TW'(PROG_CYCLES - 1);
      we      <= 1'b1;
      bulk    <= is_bulk;
      we_word <= is_bulk ? '0 : (org_x16 ? addr[WA-1:0] : addr[WA:1]);
      we_be   <= (is_bulk || org_x16) ? 2'b11 : (addr[0] ? 2'b01 : 2'b10);
      we_data <= is_ones ? 16'hFFFF : (org_x16 ? data : {data[7:0], data[7:0]});
    end else begin
      if (busy) begin
        if (timer == '0) busy <= 1'b0;
        else timer <= timer - 1'b1;
      end
      if (we) begin
        if (bulk && we_word != WA'(NW - 1)) we_word <= we_word + 1'b1;
        else we <= 1'b0;
      end
    end
  end

  initial AST_PROG_LONG: assert (PROG_CYCLES > NW); // R8

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (rst) we |-> busy); // R7
  AST_GO_IDLE: assert property (@(posedge clk) disable iff (rst) go |-> !busy); // R10

endmodule

// File: rtl/mw_cmd.sv
module mw_cmd
  import mw_pkg::*;
#(
  parameter int WA = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          org_x16,
  input  logic          cs,
  input  logic          sck,
  input  logic          di,
  input  logic          busy,
  output logic          rd_req,
  output logic [WA-1:0] rd_word,
  input  logic [15:0]   rd_q,
  output logic          go,
  output prog_kind_t    go_kind,
  output logic [WA:0]   go_addr,
  output logic [15:0]   go_data,
  output logic          wen,
  output logic          in_read,
  output logic          dout
);
  localparam int BA = WA + 1;

  mw_state_t   st;
  prog_kind_t  arm_kind;
  logic        sck_q, cs_q, sck_rise, cs_fall;
  logic [4:0]  cnt, alast, dlast;
  logic [1:0]  opc, ext_sel;
  logic [BA-1:0] addr, a_new, addr_inc;
  logic [15:0] data, shift, loadval;
  logic        rd_load, read_enter;

  assign sck_rise = sck & ~sck_q;
  assign cs_fall  = ~cs & cs_q;
  assign alast    = org_x16 ? 5'(BA - 2) : 5'(BA - 1);
  assign dlast    = org_x16 ? 5'd15 : 5'd7;
  assign a_new    = {addr[BA-2:0], di};
  assign ext_sel  = org_x16 ? a_new[WA-1:WA-2] : a_new[WA:WA-1];
  assign addr_inc = org_x16 ? {1'b0, WA'(addr[WA-1:0] + 1'b1)} : addr + 1'b1;
  assign rd_word  = org_x16 ? addr[WA-1:0] : addr[WA:1];
  assign loadval  = org_x16 ? rd_q : {(addr[0] ? rd_q[7:0] : rd_q[15:8]), 8'h00};
  assign in_read  = (st == ST_READ);
  assign read_enter = cs && sck_rise && st == ST_ADDR && cnt == alast && opc == OPC_READ;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      arm_kind <= PK_WORD;
      sck_q <= 1'b0;
      cs_q <= 1'b0;
      cnt <= '0;
      opc <= '0;
      addr <= '0;
      data <= '0;
      shift <= '0;
      rd_req <= 1'b0;
      rd_load <= 1'b0;
      go <= 1'b0;
      go_kind <= PK_WORD;
      go_addr <= '0;
      go_data <= '0;
      wen <= 1'b0;
    end else begin
      sck_q   <= sck;
      cs_q    <= cs;
      rd_req  <= 1'b0;
      go      <= 1'b0;
      rd_load <= rd_req;
      if (rd_load) shift <= loadval;
      if (!cs) begin
        st <= ST_IDLE;
        if (cs_fall && st == ST_ARMED && wen && !busy) begin
          go      <= 1'b1;
          go_kind <= arm_kind;
          go_addr <= addr;
          go_data <= data;
        end
      end else if (sck_rise) begin
        case (st)
          ST_IDLE: if (di) begin
            st   <= busy ? ST_DROP : ST_OPC;
            cnt  <= '0;
            opc  <= '0;
            addr <= '0;
            data <= '0;
          end
          ST_OPC: begin
            opc <= {opc[0], di};
            if (cnt == 5'd1) begin
              st  <= ST_ADDR;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
          ST_ADDR: begin
            addr <= a_new;
            if (cnt == alast) begin
              cnt <= '0;
              case (opc)
                OPC_READ:  begin st <= ST_READ;  rd_req <= 1'b1; end
                OPC_WRITE: begin st <= ST_DATA;  arm_kind <= PK_WORD; end
                OPC_ERASE: begin st <= ST_ARMED; arm_kind <= PK_ERASE; end
                default: begin
                  case (ext_sel)
                    EXT_EN:    begin wen <= 1'b1; st <= ST_DROP; end
                    EXT_DIS:   begin wen <= 1'b0; st <= ST_DROP; end
                    EXT_FILL:  begin st <= ST_DATA;  arm_kind <= PK_FILL; end
                    default:   begin st <= ST_ARMED; arm_kind <= PK_CLEAR; end
                  endcase
                end
              endcase
            end else cnt <= cnt + 1'b1;
          end
          ST_DATA: begin
            data <= {data[14:0], di};
            if (cnt == dlast) begin
              st  <= ST_ARMED;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
          ST_ARMED: st <= ST_DROP;
          ST_READ: begin
            shift <= {shift[14:0], 1'b0};
            if (cnt == dlast) begin
              cnt    <= '0;
              addr   <= addr_inc;
              rd_req <= 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= 1'b1;
    else if (read_enter) dout <= 1'b0;
    else if (cs && st == ST_READ) begin
      if (sck_rise) dout <= shift[15];
    end else dout <= ~busy;
  end

  AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (rst) go |=> !$past(busy)); // R10
  AST_CS_LOW_IDLE: assert property (@(posedge clk) disable iff (rst) $past(!cs) && !cs |-> !in_read); // R11

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int WORD_ADDR_W = 6,
  parameter int PROG_CYCLES = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic org_x16,
  input  logic cs,
  input  logic sck,
  input  logic di,
  output logic dout
);
  localparam int WA = WORD_ADDR_W;

  logic          rd_req, go, busy, wen, in_read, we;
  logic [WA-1:0] rd_word, we_word;
  logic [15:0]   rd_q, go_data, we_data;
  logic [WA:0]   go_addr;
  logic [1:0]    we_be;
  prog_kind_t    go_kind;

  mw_cmd #(.WA(WA)) u_cmd (
    .clk(clk), .rst(rst), .org_x16(org_x16), .cs(cs), .sck(sck), .di(di),
    .busy(busy), .rd_req(rd_req), .rd_word(rd_word), .rd_q(rd_q),
    .go(go), .go_kind(go_kind), .go_addr(go_addr), .go_data(go_data),
    .wen(wen), .in_read(in_read), .dout(dout)
  );

  mw_prog #(.WA(WA), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst(rst), .go(go), .kind(go_kind), .org_x16(org_x16),
    .addr(go_addr), .data(go_data), .busy(busy), .we(we),
    .we_word(we_word), .we_be(we_be), .we_data(we_data)
  );

  mw_mem #(.WA(WA)) u_mem (
    .clk(clk), .rd_en(rd_req), .rd_word(rd_word), .rd_q(rd_q),
    .we(we), .we_word(we_word), .we_be(we_be), .we_data(we_data)
  );

  AST_WR_ENABLED: assert property (@(posedge clk) disable iff (rst) we |-> wen); // R3
  AST_DO_LOW_BUSY: assert property (@(posedge clk) disable iff (rst) busy && $past(busy) |-> !dout); // R7
  AST_NO_READ_BUSY: assert property (@(posedge clk) disable iff (rst) busy |-> !in_read); // R10

endmodule

// File: tb/sim_mw_eeprom.sv
module sim_mw_eeprom;
  localparam int PROG = 600;

  logic clk = 1'b0, rst = 1'b1, org = 1'b1, cs = 1'b0, sck = 1'b0, di = 1'b0;
  logic dout;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [15:0] mem_m [64];

  mw_eeprom #(.WORD_ADDR_W(6), .PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst(rst), .org_x16(org), .cs(cs), .sck(sck), .di(di), .dout(dout)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  function automatic int abits(); return org ? 6 : 7; endfunction
  function automatic int dbits(); return org ? 16 : 8; endfunction
  function automatic int depth(); return org ? 64 : 128; endfunction

  function automatic logic [15:0] model_rd(input int a);
    if (org) return mem_m[a % 64];
    return a[0] ? {8'h00, mem_m[a / 2][7:0]} : {8'h00, mem_m[a / 2][15:8]};
  endfunction

  task automatic model_wr(input int a, input logic [15:0] d);
    if (org) mem_m[a % 64] = d;
    else if (a[0]) mem_m[a / 2][7:0] = d[7:0];
    else mem_m[a / 2][15:8] = d[7:0];
  endtask

  task automatic clk_bit(input logic b);
    di = b; sck = 1'b0; repeat (2) tick();
    sck = 1'b1; repeat (4) tick();
    sck = 1'b0; repeat (2) tick();
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) clk_bit(v[i]);
  endtask

  task automatic head(input logic [1:0] opc, input int a, input int lead);
    cs = 1'b1; repeat (2) tick();
    for (int i = 0; i < lead; i++) clk_bit(1'b0);
    clk_bit(1'b1);
    send(32'(opc), 2);
    send(32'(a), abits());
  endtask

  function automatic int ext_addr(input logic [1:0] sel);
    return org ? int'({sel, 4'b0}) : int'({sel, 5'b0});
  endfunction

  task automatic ext_cmd(input logic [1:0] sel);
    head(2'b00, ext_addr(sel), 0);
    cs = 1'b0; repeat (3) tick();
  endtask

  // drops cs, re-raises it to view status, returns clocks until ready
  task automatic finish_prog(output int dur);
    cs = 1'b0; tick(); cs = 1'b1; dur = 1;
    repeat (3) begin tick(); dur++; end
    while (dout == 1'b0 && dur < 5000) begin tick(); dur++; end
    cs = 1'b0; repeat (2) tick();
  endtask

  task automatic prog_op(input logic [1:0] opc, input int a, input logic [15:0] d,
                         input bit has_data, input bit expect_run, input string tag);
    int dur;
    head(opc, a, 0);
    if (has_data) send(32'(d), dbits());
    finish_prog(dur);
    if (expect_run) chk(dur >= PROG && dur <= PROG + 8, tag, dur, PROG + 3);
    else chk(dur <= 4, tag, dur, 4);
  endtask

  task automatic read_seq(input int a, input int n, input int lead, input string tag);
    logic [15:0] v;
    int cur;
    head(2'b10, a, lead);
    chk(dout == 1'b0, {tag, " dummy"}, dout, 0);
    cur = a;
    for (int k = 0; k < n; k++) begin
      v = '0;
      for (int b = 0; b < dbits(); b++) begin
        clk_bit(1'b0);
        v = {v[14:0], dout};
      end
      chk(v == model_rd(cur), tag, v, model_rd(cur));
      cur = (cur + 1) % depth();
    end
    cs = 1'b0; repeat (3) tick();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<190000", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int a, op;
    logic [15:0] d;
    void'($urandom(32'd2024));
    repeat (3) tick();
    chk(dout == 1'b1, "R12 dout in reset", dout, 1);
    rst = 1'b0; repeat (2) tick();
    chk(dout == 1'b1, "R12 dout after reset", dout, 1);

    // R3: disabled after reset, fill is ignored and never busy
    org = 1'b1;
    head(2'b00, ext_addr(2'b01), 0);
    send(32'h1234, 16);
    begin int dur; finish_prog(dur); chk(dur <= 4, "R3 fill while disabled", dur, 4); end

    // R4 R8: enable then fill
    ext_cmd(2'b11);
    head(2'b00, ext_addr(2'b01), 0);
    send(32'hA5C3, 16);
    begin int dur; finish_prog(dur); chk(dur >= PROG && dur <= PROG + 8, "R7 R8 fill busy time", dur, PROG + 3); end
    for (int i = 0; i < 64; i++) mem_m[i] = 16'hA5C3;
    read_seq(5, 1, 0, "R8 R9 fill readback");

    // R9: sequential wrap x16, then R2 x8 wrap
    prog_op(2'b01, 63, 16'h0F1E, 1'b1, 1'b1, "R6 write top word");
    model_wr(63, 16'h0F1E);
    prog_op(2'b01, 0, 16'h7788, 1'b1, 1'b1, "R6 write word 0");
    model_wr(0, 16'h7788);
    read_seq(62, 4, 0, "R9 seq wrap x16");
    org = 1'b0;
    read_seq(126, 3, 0, "R2 R9 seq wrap x8");

    // R2: byte lanes
    prog_op(2'b01, 9, 16'h003C, 1'b1, 1'b1, "R2 byte write odd");
    model_wr(9, 16'h003C);
    prog_op(2'b01, 8, 16'h00D2, 1'b1, 1'b1, "R2 byte write even");
    model_wr(8, 16'h00D2);
    org = 1'b1;
    read_seq(4, 1, 0, "R2 word view of bytes");

    // R5: erase word and byte
    prog_op(2'b11, 7, 16'h0, 1'b0, 1'b1, "R5 erase word");
    model_wr(7, 16'hFFFF);
    read_seq(7, 1, 0, "R5 erased word");
    org = 1'b0;
    prog_op(2'b11, 1, 16'h0, 1'b0, 1'b1, "R5 erase byte");
    model_wr(1, 16'h00FF);
    org = 1'b1;
    read_seq(0, 1, 0, "R5 erased low byte");

    // random mix
    for (int it = 0; it < 30; it++) begin
      org = 1'($urandom);
      op = int'($urandom % 3);
      a = int'($urandom % depth());
      d = 16'($urandom);
      if (!org) d = {8'h00, d[7:0]};
      if (op == 0) begin
        prog_op(2'b01, a, d, 1'b1, 1'b1, "R6 random write");
        model_wr(a, d);
      end else if (op == 1) begin
        prog_op(2'b11, a, 16'h0, 1'b0, 1'b1, "R5 random erase");
        model_wr(a, 16'hFFFF);
      end
      read_seq(a, 2, 0, "R9 random read");
    end

    // R6: extra clock before cs fall drops the write
    org = 1'b1;
    head(2'b01, 12, 0);
    send(32'h5555, 16);
    clk_bit(1'b0);
    begin int dur; finish_prog(dur); chk(dur <= 4, "R6 late cs dropped", dur, 4); end
    read_seq(12, 1, 0, "R6 word unchanged");

    // R11: abandoned frame, then a clean read with leading zeros (R1)
    cs = 1'b1; repeat (2) tick();
    clk_bit(1'b1); send(32'b11, 2); send(32'b101, 3);
    cs = 1'b0; repeat (3) tick();
    read_seq(12, 1, 3, "R1 R11 read after abort");
    begin int dur; cs = 1'b1; repeat (3) tick(); dur = 0; chk(dout == 1'b1, "R11 no program from abort", dout, 1); cs = 1'b0; repeat (2) tick(); end

    // R10: second write during busy is ignored
    head(2'b01, 2, 0);
    send(32'h1357, 16);
    cs = 1'b0; repeat (2) tick();
    model_wr(2, 16'h1357);
    head(2'b01, 3, 0);
    send(32'h2468, 16);
    begin int dur; finish_prog(dur); end
    repeat (PROG) tick();
    read_seq(2, 2, 0, "R10 busy write ignored");

    // R4: disable blocks, then clear after re-enable
    ext_cmd(2'b00);
    prog_op(2'b01, 20, 16'hBEEF, 1'b1, 1'b0, "R4 write after disable");
    read_seq(20, 1, 0, "R4 word kept after disable");
    ext_cmd(2'b11);
    prog_op(2'b00, ext_addr(2'b10), 16'h0, 1'b0, 1'b1, "R8 clear busy");
    for (int i = 0; i < 64; i++) mem_m[i] = 16'hFFFF;
    read_seq(30, 3, 0, "R8 clear all ones");

    // R3: reset clears the enable latch
    rst = 1'b1; repeat (2) tick(); rst = 1'b0; repeat (2) tick();
    prog_op(2'b01, 30, 16'h0000, 1'b1, 1'b0, "R3 write after reset");
    read_seq(30, 1, 0, "R3 word kept after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1'b1;
    $finish;
  end

endmodule